// File: doc/BRIEF.md
# I2C Master SCL Bit Synchronizer

This block produces the SCL clock of an I2C master and paces every bit by what the bus line actually does, not by its own timers alone. The block pulls SCL low for a programmed number of cycles. It then stops driving the line and leaves it to the pull-up. A fixed settling delay follows, and its length is picked by a 2-bit select. After that delay the block keeps sampling the synchronized SCL input until the line reads high, and only then does it start timing the high phase. A slave that stretches the clock, or a heavily loaded line that rises slowly, therefore lengthens the bit. The high time is never shortened.

The block runs on a clock at twice the reference rate. The four settling delays of 7.5, 19.5, 17.5 and 41.5 reference cycles therefore become whole counts of 15, 39, 35 and 83 ticks. A one-cycle bit tick marks the end of each bit. Synchronization runs only while the enable (master operation) is high. Dropping the enable frees the line and returns the block to idle.

Top module: `scl_bitsync`

## Requirements
- R1: During and right after synchronous reset, `scl_oe` and `bit_tick` are both 0.
- R2: While `en` is low, `scl_oe` and `bit_tick` stay 0 whatever `scl_in` does. The cycle after `en` is sampled low, `scl_oe` is 0.
- R3: Each low phase drives `scl_oe` high for exactly `low_len` consecutive cycles (`low_len` >= 1).
- R4: After release, the block waits D cycles before its first sample of SCL. D is 15, 39, 35 or 83 for `clk_sel` = 0, 1, 2 or 3. If the line is already high, `scl_oe` stays low for D + 1 + `high_len` cycles.
- R5: `scl_in` passes through two flops before it is sampled, and the high phase starts only after the sampled line reads 1. If the line first reads high R cycles after release, `scl_oe` stays low for max(D, R+2) + 1 + `high_len` cycles.
- R6: `bit_tick` is a one-cycle pulse. It is raised in the first cycle of the next low phase, so it coincides with the rising edge of `scl_oe`, and it is never raised while `scl_oe` is 0.
- R7: After `en` is dropped at any phase and raised again, counting restarts from zero, so the first low phase lasts the full `low_len`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, twice the reference rate |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Master operation enable |
| clk_sel | input | 2 | Selects the settling delay after release |
| low_len | input | CNT_W | Low phase length in cycles |
| high_len | input | CNT_W | High phase length in cycles |
| scl_in | input | 1 | Observed SCL line level (asynchronous) |
| scl_oe | output | 1 | 1 pulls SCL low; 0 leaves it to the pull-up |
| bit_tick | output | 1 | One-cycle pulse at the end of each bit |

## Verification
The assertions assume that `clk_sel`, `low_len` and `high_len` hold steady while `en` is high, and that both lengths are nonzero. A length check counted over a phase would be meaningless if its limit moved partway through. The bench changes configuration only while `en` is low, and it uses only nonzero lengths. Its line model keeps SCL low whenever `scl_oe` is 1, as open-drain wiring does. When a release begins, the model holds the line low for a chosen R more cycles.

// File: rtl/sclsync_pkg.sv
package sclsync_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_LOW  = 3'd1,
        PH_REL  = 3'd2,
        PH_MON  = 3'd3,
        PH_HIGH = 3'd4
    } phase_e;

    localparam int MON_W = 7;

    // Settling delay after release, in ticks of the doubled clock
    function automatic logic [MON_W-1:0] settle_ticks(input logic [1:0] sel);
        logic [MON_W-1:0] t;
        case (sel)
            2'd0:    t = 7'd15;
            2'd1:    t = 7'd39;
            2'd2:    t = 7'd35;
            default: t = 7'd83;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/scl_sync_chain.sv
module scl_sync_chain #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/phase_timer.sv
module phase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic [W-1:0] limit,
    output logic         last
);
    logic [W-1:0] cnt;
    logic [W-1:0] lim_m1;

    assign lim_m1 = limit - W'(1);
    assign last   = (cnt == lim_m1);

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else            cnt <= cnt + W'(1);
    end
endmodule

// File: rtl/scl_bitsync.sv
module scl_bitsync
    import sclsync_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int SYNC_ST = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [1:0]       clk_sel,
    input  logic [CNT_W-1:0] low_len,
    input  logic [CNT_W-1:0] high_len,
    input  logic             scl_in,
    output logic             scl_oe,
    output logic             bit_tick
);
    localparam int CW = (CNT_W > MON_W) ? CNT_W : MON_W;

    phase_e        st, nxt;
    logic          scl_s;
    logic          t_last;
    logic          t_clr;
    logic [CW-1:0] t_lim;
    logic          tick_q;

    scl_sync_chain #(.STAGES(SYNC_ST)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (scl_in),
        .q_sync  (scl_s)
    );

    always_comb begin
        case (st)
            PH_LOW:  t_lim = CW'(low_len);
            PH_REL:  t_lim = CW'(settle_ticks(clk_sel));
            PH_HIGH: t_lim = CW'(high_len);
            default: t_lim = CW'(1);
        endcase
    end

    always_comb begin
        nxt = st;
        case (st)
            PH_IDLE: nxt = PH_LOW;
            PH_LOW:  if (t_last) nxt = PH_REL;
            PH_REL:  if (t_last) nxt = PH_MON;
            PH_MON:  if (scl_s)  nxt = PH_HIGH;
            PH_HIGH: if (t_last) nxt = PH_LOW;
            default: nxt = PH_IDLE;
        endcase
        if (!en) nxt = PH_IDLE;
    end

    assign t_clr = (nxt != st) || (st == PH_IDLE) || (st == PH_MON);

    phase_timer #(.W(CW)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clr   (t_clr),
        .limit (t_lim),
        .last  (t_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= PH_IDLE;
            tick_q <= 1'b0;
        end else begin
            st     <= nxt;
            tick_q <= en && (st == PH_HIGH) && t_last;
        end
    end

    assign scl_oe   = (st == PH_LOW);
    assign bit_tick = tick_q;
endmodule

// File: rtl/scl_bitsync_chk.sv
module scl_bitsync_chk
    import sclsync_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic [1:0]       clk_sel,
    input logic [CNT_W-1:0] low_len,
    input logic             scl_oe,
    input logic             bit_tick,
    input phase_e           st,
    input logic             scl_s
);
    logic [15:0] lo_run;
    logic [15:0] rel_run;

    always_ff @(posedge clk) begin
        if (rst || !scl_oe) lo_run <= '0;
        else                lo_run <= lo_run + 16'd1;
        if (rst || st != PH_REL) rel_run <= '0;
        else                     rel_run <= rel_run + 16'd1;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) $past(rst) |-> (!scl_oe && !bit_tick));

    // R2
    disabled_released_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(en) |-> !scl_oe);

    // R3
    low_len_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(scl_oe) && !scl_oe && $past(en)) |-> (lo_run == 16'(low_len)));

    // R4
    settle_len_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(st) == PH_REL && st == PH_MON) |-> (rel_run == 16'(settle_ticks(clk_sel))));

    // R5
    high_after_line_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(st) == PH_MON && st == PH_HIGH) |-> $past(scl_s));

    // R6
    tick_single_chk: assert property (@(posedge clk) disable iff (rst)
        bit_tick |=> !bit_tick);

    // R6
    tick_on_low_chk: assert property (@(posedge clk) disable iff (rst)
        bit_tick |-> scl_oe);
endmodule

bind scl_bitsync scl_bitsync_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .clk_sel  (clk_sel),
    .low_len  (low_len),
    .scl_oe   (scl_oe),
    .bit_tick (bit_tick),
    .st       (st),
    .scl_s    (scl_s)
);

// File: tb/scl_bitsync_tb.sv
module scl_bitsync_tb;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             en = 1'b0;
    logic [1:0]       clk_sel = 2'd0;
    logic [CNT_W-1:0] low_len = 8'd3;
    logic [CNT_W-1:0] high_len = 8'd1;
    logic             scl_in = 1'b0;
    logic             scl_oe;
    logic             bit_tick;

    int tests = 0;
    int fails = 0;
    int hold_r = 0;
    int rel_cnt = 0;
    int cyc = 0;
    bit idle_noise = 1'b0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    scl_bitsync #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .en(en), .clk_sel(clk_sel),
        .low_len(low_len), .high_len(high_len),
        .scl_in(scl_in), .scl_oe(scl_oe), .bit_tick(bit_tick)
    );

    // Open-drain line: low while driven, then held low hold_r more cycles
    always @(negedge clk) begin
        if (idle_noise) begin
            scl_in <= ~scl_in;
        end else if (scl_oe) begin
            rel_cnt = 0;
            scl_in <= 1'b0;
        end else begin
            scl_in <= (rel_cnt >= hold_r);
            rel_cnt = rel_cnt + 1;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !finished) begin
            fails = fails + 1;
            tests = tests + 1;
            $display("FAIL watchdog: run did not end (act %0d cycles, exp < 150000)", cyc);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests = tests + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int settle(input int sel);
        case (sel)
            0: return 15;
            1: return 39;
            2: return 35;
            default: return 83;
        endcase
    endfunction

    task automatic run_combo(input int sel, input int r, input int lo_l, input int hi_l);
        int d, exp_hi, lo, hi, extra;
        d = settle(sel);
        exp_hi = ((d > r + 2) ? d : r + 2) + 1 + hi_l;
        @(negedge clk);
        clk_sel = 2'(sel);
        low_len = 8'(lo_l);
        high_len = 8'(hi_l);
        hold_r = r;
        en = 1'b1;
        @(negedge clk);
        for (int b = 0; b < 2; b++) begin
            lo = 0;
            extra = 0;
            while (scl_oe && lo < 1000) begin
                if (lo > 0 && bit_tick) extra = extra + 1;
                lo = lo + 1;
                @(negedge clk);
            end
            // R3 (first bit after enable also covers R7)
            chk(lo == lo_l, (b == 0) ? "R3/R7 first low" : "R3 low", lo, lo_l);
            chk(extra == 0, "R6 tick width", extra, 0);
            hi = 0;
            extra = 0;
            while (!scl_oe && hi < 1000) begin
                if (bit_tick) extra = extra + 1;
                hi = hi + 1;
                @(negedge clk);
            end
            chk(hi == exp_hi, (r + 2 > d) ? "R5 stretched release" : "R4 settle release", hi, exp_hi);
            chk(extra == 0, "R6 no tick while released", extra, 0);
            chk(bit_tick == 1'b1, "R6 tick at low start", int'(bit_tick), 1);
        end
        en = 1'b0;
        @(negedge clk);
        chk(scl_oe == 1'b0, "R2 release on disable", int'(scl_oe), 0);
    endtask

    initial begin
        int lo, waited;
        repeat (3) @(negedge clk);
        chk(scl_oe == 1'b0 && bit_tick == 1'b0, "R1 reset outputs", int'({scl_oe, bit_tick}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(scl_oe == 1'b0 && bit_tick == 1'b0, "R1 after reset", int'({scl_oe, bit_tick}), 0);

        // R2: idle with a toggling line
        idle_noise = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk(scl_oe == 1'b0 && bit_tick == 1'b0, "R2 idle ignores line", int'({scl_oe, bit_tick}), 0);
        end
        idle_noise = 1'b0;

        for (int sel = 0; sel < 4; sel++)
            for (int ri = 0; ri < 4; ri++)
                for (int h = 1; h <= 4; h += 3)
                    run_combo(sel, (ri == 0) ? 0 : (ri == 1) ? 10 : (ri == 2) ? 40 : 90, 3, h);

        // R7: disable during the settling wait, then re-enable
        @(negedge clk);
        clk_sel = 2'd3;
        low_len = 8'd5;
        high_len = 8'd2;
        hold_r = 0;
        en = 1'b1;
        waited = 0;
        @(negedge clk);
        while (scl_oe && waited < 100) begin waited++; @(negedge clk); end
        repeat (4) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        chk(scl_oe == 1'b0, "R2 disable mid wait", int'(scl_oe), 0);
        @(negedge clk);
        en = 1'b1;
        @(negedge clk);
        lo = 0;
        while (scl_oe && lo < 1000) begin lo++; @(negedge clk); end
        chk(lo == 5, "R7 full low after re-enable", lo, 5);
        en = 1'b0;
        repeat (3) @(negedge clk);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule